// File: doc/BRIEF.md
# Interrupt Poll and End-of-Interrupt Unit

This block keeps two flag vectors for a small interrupt controller: one bit per source that is waiting (pending) and one bit per source whose handler is running (in service). Sources have a fixed priority by index, with index 0 the most urgent. Each source carries a 5-bit type code, equal to a base value plus its index. Software sees the block through two 16-bit registers on a simple read/write port. The poll register tells whether a request can be reported and which type it is. The end-of-interrupt register releases in-service flags.

An acknowledge strobe hands the reported request to service. End-of-interrupt writes release a source in one of three ways. In master mode, a specific write names the source by its type code, and a non-specific write releases the most urgent source in service. In slave mode, the write names the source by a 3-bit priority level. A request whose level is equal to or below that of the most urgent source in service is held back from the poll register. It is reported once that in-service flag is released.

Top module: `poll_eoi_unit`

## Requirements
- R1: Reading the poll address (`reg_addr` = 0) returns bit 15 = 1 exactly when some pending source is reportable. Bits 4..0 then hold that source's type code. When bit 15 is 0, bits 4..0 read 0.
- R2: Poll bits 14..5 always read 0.
- R3: Among reportable pending sources, the lowest index wins. Source i has type code `TYPE_BASE` + i (default base 8, so source 3 reads 11).
- R4: A pending source whose index is greater than or equal to the lowest in-service index is not reported. It is reported after that in-service flag clears.
- R5: A cycle with `ack` high and a reportable source sets that source's in-service flag and clears its pending flag on the same edge. A cycle with `ack` high and nothing reportable changes nothing.
- R6: In master mode, a write to the end-of-interrupt address (`reg_addr` = 1) with bit 15 = 0 clears the in-service flag of the source whose type code equals bits 4..0. A code matching no source clears nothing.
- R7: In master mode, an end-of-interrupt write with bit 15 = 1 clears the in-service flag of the lowest-index source in service. With none in service, it does nothing.
- R8: With `slave_mode` high, an end-of-interrupt write clears the in-service flag at the level given by bits 2..0. Bit 15 and bits 4..3 are ignored.
- R9: A synchronous `rst` clears every pending and in-service flag, so the poll register reads 0 afterwards.
- R10: Reading the end-of-interrupt address returns 0. Writes to the poll address change no state.
- R11: A high `irq_req` bit sets that source's pending flag. The flag stays set until the source is acknowledged. A request arriving in the same cycle that its source is acknowledged leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slave_mode | input | 1 | 1 selects level-based end-of-interrupt decoding |
| irq_req | input | NUM_SRC | Request strobes, one per source |
| ack | input | 1 | Moves the reported source into service |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = poll register, 1 = end-of-interrupt register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |

## Verification
The hardest state to reach is two sources in service at once, with a third held pending behind them. Only that state shows that a non-specific release picks the lowest in-service index, and that masking follows the lowest remaining in-service index. The in-service flags have no read path, so the stimulus builds this state indirectly. It acknowledges a mid-level source, then raises a more urgent one and acknowledges that too, and leaves a less urgent request waiting. Each release is then judged by which type code, if any, the poll register shows next.

// File: rtl/poll_eoi_pkg.sv
package poll_eoi_pkg;
    localparam int REG_W      = 16;
    localparam int TYPE_W     = 5;
    localparam int LEVEL_W    = 3;
    localparam int NSPEC_BIT  = 15;
    localparam int VALID_BIT  = 15;

    typedef enum logic {
        ADDR_POLL = 1'b0,
        ADDR_EOI  = 1'b1
    } reg_addr_e;

    typedef enum logic [1:0] {
        CLR_SPECIFIC = 2'd0,
        CLR_NONSPEC  = 2'd1,
        CLR_LEVEL    = 2'd2
    } clr_kind_e;
endpackage

// File: rtl/poll_eoi_prio_enc.sv
module poll_eoi_prio_enc #(
    parameter int N     = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/poll_eoi_clear_dec.sv
module poll_eoi_clear_dec
    import poll_eoi_pkg::*;
#(
    parameter int N         = 8,
    parameter int TYPE_BASE = 8,
    localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
    input  logic              eoi_wr,
    input  logic              slave_mode,
    input  logic              nspec,
    input  logic [TYPE_W-1:0] code,
    input  logic              svc_found,
    input  logic [IDX_W-1:0]  svc_idx,
    output logic [N-1:0]      clr_mask
);
    clr_kind_e kind;

    always_comb begin
        if (slave_mode)  kind = CLR_LEVEL;
        else if (nspec)  kind = CLR_NONSPEC;
        else             kind = CLR_SPECIFIC;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        logic type_hit;
        logic level_hit;
        logic top_hit;

        assign type_hit  = (code == TYPE_W'(TYPE_BASE + i));
        assign level_hit = (code[LEVEL_W-1:0] == LEVEL_W'(i)) && (i < (1 << LEVEL_W));
        assign top_hit   = svc_found && (svc_idx == IDX_W'(i));

        always_comb begin
            unique case (kind)
                CLR_LEVEL:   clr_mask[i] = eoi_wr && level_hit;
                CLR_NONSPEC: clr_mask[i] = eoi_wr && top_hit;
                default:     clr_mask[i] = eoi_wr && type_hit;
            endcase
        end
    end
endmodule

// File: rtl/poll_eoi_unit.sv
module poll_eoi_unit
    import poll_eoi_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int TYPE_BASE = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slave_mode,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               ack,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] svc;
    } state_t;

    state_t st_d, st_q;

    logic               pend_found, svc_found, rep_valid, eoi_wr;
    logic [IDX_W-1:0]   pend_idx, svc_idx;
    logic [NUM_SRC-1:0] ack_mask, clr_mask;
    logic [TYPE_W-1:0]  rep_type;
    logic [REG_W-1:0]   poll_word;
    logic               unused_wdata;

    poll_eoi_prio_enc #(.N(NUM_SRC)) u_pend_enc (
        .vec   (st_q.pend),
        .found (pend_found),
        .idx   (pend_idx)
    );

    poll_eoi_prio_enc #(.N(NUM_SRC)) u_svc_enc (
        .vec   (st_q.svc),
        .found (svc_found),
        .idx   (svc_idx)
    );

    assign eoi_wr = reg_wr && (reg_addr == ADDR_EOI);

    poll_eoi_clear_dec #(.N(NUM_SRC), .TYPE_BASE(TYPE_BASE)) u_clear_dec (
        .eoi_wr     (eoi_wr),
        .slave_mode (slave_mode),
        .nspec      (reg_wdata[NSPEC_BIT]),
        .code       (reg_wdata[TYPE_W-1:0]),
        .svc_found  (svc_found),
        .svc_idx    (svc_idx),
        .clr_mask   (clr_mask)
    );

    assign unused_wdata = ^reg_wdata[NSPEC_BIT-1:TYPE_W];

    // a source is reportable only if it outranks everything in service
    assign rep_valid = pend_found && (!svc_found || (pend_idx < svc_idx));
    assign rep_type  = rep_valid ? TYPE_W'(TYPE_BASE + int'(pend_idx)) : '0;
    assign ack_mask  = (ack && rep_valid) ? (NUM_SRC'(1) << pend_idx) : '0;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~ack_mask) | irq_req;
        st_d.svc  = (st_q.svc & ~clr_mask) | ack_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        poll_word                = '0;
        poll_word[VALID_BIT]     = rep_valid;
        poll_word[TYPE_W-1:0]    = rep_type;
        reg_rdata = (reg_addr == ADDR_POLL) ? poll_word : '0;
    end
endmodule

// File: rtl/poll_eoi_unit_chk.sv
module poll_eoi_unit_chk
    import poll_eoi_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               slave_mode,
    input logic               ack,
    input logic               reg_wr,
    input logic               reg_addr,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [REG_W-1:0]   reg_rdata,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] svc_q,
    input logic               rep_valid,
    input logic [IDX_W-1:0]   pend_idx
);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[14:5] == '0);

    p_valid_needs_pend_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_POLL && reg_rdata[VALID_BIT]) |-> (pend_q != '0));

    p_eoi_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == ADDR_EOI) |-> (reg_rdata == '0));

    p_ack_enters_svc_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && rep_valid) |=> svc_q[$past(pend_idx)]);

    p_idle_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (ack && !rep_valid && !(reg_wr && reg_addr == ADDR_EOI)) |=> $stable(svc_q));

    p_poll_write_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_POLL && !ack) |=> $stable(svc_q));

    p_nspec_one_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_EOI && !slave_mode && reg_wdata[NSPEC_BIT] && !ack)
        |=> ($countones(svc_q) + 1 >= $past($countones(svc_q))));

    p_reset_clears_r9: assert property (@(posedge clk)
        $past(rst) |-> (pend_q == '0 && svc_q == '0));
endmodule

bind poll_eoi_unit poll_eoi_unit_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slave_mode (slave_mode),
    .ack        (ack),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .pend_q     (st_q.pend),
    .svc_q      (st_q.svc),
    .rep_valid  (rep_valid),
    .pend_idx   (pend_idx)
);

// File: tb/poll_eoi_unit_bench.sv
`timescale 1ns/1ps
module poll_eoi_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        slave_mode;
    logic [7:0]  irq_req;
    logic        ack;
    logic        reg_wr;
    logic        reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    poll_eoi_unit u_poll_eoi_unit (
        .clk        (clk),
        .rst        (rst),
        .slave_mode (slave_mode),
        .irq_req    (irq_req),
        .ack        (ack),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata)
    );

    // {slave, req[7:0], ack, wr, addr, wdata[15:0], expected poll[15:0]}
    localparam int NV = 13;
    localparam logic [43:0] VEC [NV] = '{
        {1'b0, 8'h28, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h800B}, // R11 R3: src3,src5 pend, 3 wins
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R5 R4: 3 in service, 5 masked
        {1'b0, 8'h02, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h8009}, // R4 R1: src1 outranks svc 3
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R5: svc {1,3}
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 16'h8000, 16'h0000}, // R7: nonspecific drops 1, 3 remains
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 16'h0009, 16'h0000}, // R6: type 9 not in service
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 16'h000B, 16'h800D}, // R6: type 11 drops 3, 5 shows
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'h800D, 16'h800D}, // R10: poll write ignored
        {1'b0, 8'h40, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000}, // R5: 5 in service, 6 masked
        {1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 16'h8003, 16'h0000}, // R8: level 3 not in service
        {1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 16'h0015, 16'h800E}, // R8: level 5 (bit4 ignored)
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 16'h8000, 16'h800E}, // R7: nonspecific, none in service
        {1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h8008}  // R3: src0 type 8
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        irq_req = '0; ack = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0;
        reg_wdata = '0; slave_mode = 1'b0;
    endtask

    task automatic drive(input logic s, input logic [7:0] rq, input logic a,
                         input logic w, input logic ad, input logic [15:0] d);
        @(negedge clk);
        slave_mode = s; irq_req = rq; ack = a; reg_wr = w; reg_addr = ad; reg_wdata = d;
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic poll_check(input string tag, input logic [15:0] exp);
        reg_addr = 1'b0;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        rst = 1'b1;
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        poll_check("R9 reset poll", 16'h0000);

        for (int v = 0; v < NV; v++) begin
            drive(VEC[v][43], VEC[v][42:35], VEC[v][34], VEC[v][33], VEC[v][32], VEC[v][31:16]);
            poll_check($sformatf("vector %0d R1", v), VEC[v][15:0]);
        end

        // R10: end-of-interrupt address reads zero while a request is reportable
        reg_addr = 1'b1;
        #1;
        check("R10 eoi read", reg_rdata, 16'h0000);
        reg_addr = 1'b0;

        // R9: reset mid-operation clears pending src0
        do_reset();
        poll_check("R9 reset clears", 16'h0000);

        // R5: ack with nothing reportable is ignored; src7 then reportable
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0000);
        poll_check("R5 idle ack", 16'h0000);
        drive(1'b0, 8'h80, 1'b0, 1'b0, 1'b0, 16'h0000);
        poll_check("R5 no stray service", 16'h800F);

        // R11: request with ack of same source keeps pending
        do_reset();
        drive(1'b0, 8'h04, 1'b0, 1'b0, 1'b0, 16'h0000);
        poll_check("R11 src2 pend", 16'h800A);
        drive(1'b0, 8'h04, 1'b1, 1'b0, 1'b0, 16'h0000);
        poll_check("R4 equal level masked", 16'h0000);
        drive(1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 16'h0002);
        poll_check("R11 re-pended src2", 16'h800A);

        // R6: unmatched type code clears nothing; R2 reserved bits stay zero
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h0000);
        drive(1'b0, 8'h08, 1'b0, 1'b0, 1'b0, 16'h0000);
        drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 16'h001F);
        poll_check("R6 unmatched code", 16'h0000);
        drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 16'h000A);
        poll_check("R6 type 10 drops src2", 16'h800B);
        check("R2 reserved bits", {6'd0, reg_rdata[14:5]}, 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule